// File: doc/BRIEF.md
# Rising-Edge Gated Word Shift Register

This block is a serial-in shift register whose length is a whole number of words, from a single word up to a configured maximum. It is built for a scan-driven control engine: the surrounding logic raises a one-cycle evaluation strobe once per scan. The block samples its three control inputs only on strobe cycles: a data bit, a shift condition and a clear.

A shift takes place only when the shift condition is seen high at the current strobe and was low at the strobe before it, and clear is low. The data bit then enters bit 0 of word 0, which is the rightmost word. Every other bit moves one place toward the leftmost end, and the top bit of the last word is dropped. While clear is high at a strobe, the register is forced to zero and cannot shift. The shift-condition history is still updated on those strobes. A condition that is already high when clear is released therefore does not count as a rising edge.

The contents are available as one flat vector and through a word-indexed read port. The word count is a parameter, and the block has no status outputs.

Top module: `wordrange_shift_reg`

## Requirements
- R1: An asynchronous active-low reset `rst_n` drives every register bit to 0 and clears the stored shift-condition history to 0. After release, a high `shift_cond` at the first strobe is treated as a rising edge.
- R2: On a clock edge where `eval`=1, `clr`=0, `shift_cond`=1 and the previous strobe saw `shift_cond`=0, `din` enters bit 0 of `reg_flat`, so a 1 enters when `din`=1 and a 0 when `din`=0.
- R3: On a shift, bit i of `reg_flat` moves to bit i+1. Bit WORD_W-1 of word k therefore becomes bit 0 of word k+1, and the top bit (NUM_WORDS*WORD_W-1) is discarded.
- R4: A strobe at which `shift_cond` stays high, stays low, or falls from high to low leaves `reg_flat` unchanged.
- R5: A strobe with `clr`=1 makes `reg_flat` all zero, whatever `shift_cond` and `din` are, and no shift happens at any strobe while `clr` stays high.
- R6: The shift-condition history is updated at strobes with `clr`=1. If `shift_cond` is high at the strobe that sees `clr`=1 and stays high through the first strobe after `clr` drops, no shift happens.
- R7: On cycles with `eval`=0, neither the contents nor the shift-condition history change. A condition that rises and falls between strobes causes no shift. A condition that is low at one strobe and high at the next causes a shift, however many idle cycles lie between the two strobes.
- R8: `rd_word` shows bits [sel*WORD_W+WORD_W-1 : sel*WORD_W] of `reg_flat` for `rd_sel`=sel below NUM_WORDS, and shows 0 for any `rd_sel` of NUM_WORDS or more. The port is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| eval | input | 1 | One-cycle evaluation strobe |
| din | input | 1 | Bit shifted into bit 0 |
| shift_cond | input | 1 | Shift condition, acted on at a low-to-high change between strobes |
| clr | input | 1 | Clears the register and blocks shifting while high |
| rd_sel | input | $clog2(NUM_WORDS)+1 | Word index for the read port |
| rd_word | output | WORD_W | Selected word, or 0 when the index is out of range |
| reg_flat | output | NUM_WORDS*WORD_W | Whole register, word 0 in the low bits |

## Verification
The checker assumes that `eval`, `din`, `shift_cond` and `clr` are synchronous to `clk` and free of X on strobe cycles. It also assumes that reset is the only asynchronous event. The checker keeps its own copy of the condition history, so its properties are valid only if the strobe and condition are stable across the sampling edge. The bench changes every input on the falling clock edge, holds each input for a whole cycle, and asserts and releases reset away from the rising edge. It runs strobed and idle cycles back to back and shifts far more bits than the register holds.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

   // Action decided for one clock cycle
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_SHIFT = 2'd1,
      ACT_CLEAR = 2'd2
   } wsr_act_e;

   // Control inputs as sampled on a strobe
   typedef struct packed {
      logic din;
      logic cond;
      logic clr;
   } wsr_ctrl_t;

   localparam int unsigned WSR_MAX_WORDS = 64;

endpackage

// File: rtl/wsr_edge_ctrl.sv
module wsr_edge_ctrl
   import wsr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      eval,
   input  wsr_ctrl_t ctrl,
   output wsr_act_e  act
);

   logic cond_prev_q;

   // History of the shift condition, advanced only on strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_prev_q <= 1'b0;
      end else if (eval) begin
         cond_prev_q <= ctrl.cond;
      end
   end

   always_comb begin
      act = ACT_HOLD;
      if (eval) begin
         if (ctrl.clr) begin
            act = ACT_CLEAR;
         end else if (ctrl.cond && !cond_prev_q) begin
            act = ACT_SHIFT;
         end
      end
   end

endmodule

// File: rtl/wsr_word_cell.sv
module wsr_word_cell
   import wsr_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wsr_act_e          act,
   input  logic              carry_in,
   output logic [WORD_W-1:0] q,
   output logic              carry_out
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("wsr_word_cell: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0;
      end else begin
         unique case (act)
            ACT_CLEAR: q_r <= '0;
            ACT_SHIFT: q_r <= {q_r[WORD_W-2:0], carry_in};
            default:   q_r <= q_r;
         endcase
      end
   end

   assign q         = q_r;
   assign carry_out = q_r[WORD_W-1];

endmodule

// File: rtl/wsr_read_mux.sv
module wsr_read_mux #(
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned SEL_W     = $clog2(NUM_WORDS) + 1
) (
   input  logic [NUM_WORDS*WORD_W-1:0] flat,
   input  logic [SEL_W-1:0]            rd_sel,
   output logic [WORD_W-1:0]           rd_word
);

   generate
      if (NUM_WORDS == 1) begin : g_single
         assign rd_word = (rd_sel == '0) ? flat : '0;
      end else begin : g_multi
         always_comb begin
            rd_word = '0;
            for (int i = 0; i < NUM_WORDS; i++) begin
               if (rd_sel == SEL_W'(i)) begin
                  rd_word = flat[i*WORD_W +: WORD_W];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wordrange_shift_reg.sv
module wordrange_shift_reg
   import wsr_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned WORD_W    = 16,
   localparam int unsigned SEL_W    = $clog2(NUM_WORDS) + 1,
   localparam int unsigned TOTAL_W  = NUM_WORDS * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               eval,
   input  logic               din,
   input  logic               shift_cond,
   input  logic               clr,
   input  logic [SEL_W-1:0]   rd_sel,
   output logic [WORD_W-1:0]  rd_word,
   output logic [TOTAL_W-1:0] reg_flat
);

   generate
      if (NUM_WORDS < 1 || NUM_WORDS > WSR_MAX_WORDS) begin : g_bad_count
         $error("wordrange_shift_reg: NUM_WORDS out of range");
      end
   endgenerate

   wsr_ctrl_t ctrl;
   wsr_act_e  act;

   assign ctrl.din  = din;
   assign ctrl.cond = shift_cond;
   assign ctrl.clr  = clr;

   wsr_edge_ctrl u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .eval  (eval),
      .ctrl  (ctrl),
      .act   (act)
   );

   // Carry chain: entry k feeds word k; entry 0 is the serial input
   logic [NUM_WORDS:0] carry;
   assign carry[0] = din;

   genvar w;
   generate
      for (w = 0; w < NUM_WORDS; w++) begin : g_word
         wsr_word_cell #(
            .WORD_W (WORD_W)
         ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .act       (act),
            .carry_in  (carry[w]),
            .q         (reg_flat[w*WORD_W +: WORD_W]),
            .carry_out (carry[w+1])
         );
      end
   endgenerate

   // Top carry is the discarded bit; no consumer by design
   logic carry_drop;
   assign carry_drop = carry[NUM_WORDS];

   wsr_read_mux #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W),
      .SEL_W     (SEL_W)
   ) u_rd (
      .flat    (reg_flat),
      .rd_sel  (rd_sel),
      .rd_word (rd_word)
   );

endmodule

// File: rtl/wsr_checker.sv
module wsr_checker #(
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned WORD_W    = 16,
   localparam int unsigned SEL_W    = $clog2(NUM_WORDS) + 1,
   localparam int unsigned TOTAL_W  = NUM_WORDS * WORD_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               eval,
   input logic               din,
   input logic               shift_cond,
   input logic               clr,
   input logic [SEL_W-1:0]   rd_sel,
   input logic [WORD_W-1:0]  rd_word,
   input logic [TOTAL_W-1:0] reg_flat
);

   // Checker's own copy of the strobe-sampled condition history
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    seen_q <= 1'b0;
      else if (eval) seen_q <= shift_cond;
   end

   logic fire;
   assign fire = eval && !clr && shift_cond && !seen_q;

   AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> reg_flat == {$past(reg_flat[TOTAL_W-2:0]), $past(din)}); // R3

   AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !clr && !fire) |=> $stable(reg_flat)); // R4

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && clr) |=> reg_flat == '0); // R5

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !eval |=> $stable(reg_flat)); // R7

   always_comb begin
      if (rst_n && rd_sel >= SEL_W'(NUM_WORDS)) begin
         AST_RD_OUT_OF_RANGE: assert (rd_word == '0); // R8
      end
   end

endmodule

bind wordrange_shift_reg wsr_checker #(
   .NUM_WORDS (NUM_WORDS),
   .WORD_W    (WORD_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .eval       (eval),
   .din        (din),
   .shift_cond (shift_cond),
   .clr        (clr),
   .rd_sel     (rd_sel),
   .rd_word    (rd_word),
   .reg_flat   (reg_flat)
);

// File: tb/wordrange_shift_reg_tb_top.sv
`timescale 1ns/1ps
module wordrange_shift_reg_tb_top;

   localparam int unsigned NW    = 4;
   localparam int unsigned WW    = 16;
   localparam int unsigned SEL_W = $clog2(NW) + 1;
   localparam int unsigned TW    = NW * WW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            eval = 1'b0;
   logic            din = 1'b0;
   logic            shift_cond = 1'b0;
   logic            clr = 1'b0;
   logic [SEL_W-1:0] rd_sel = '0;
   logic [WW-1:0]   rd_word;
   logic [TW-1:0]   reg_flat;

   always #2.5 clk = ~clk;

   wordrange_shift_reg #(.NUM_WORDS(NW), .WORD_W(WW)) dut_i (
      .clk(clk), .rst_n(rst_n), .eval(eval), .din(din),
      .shift_cond(shift_cond), .clr(clr), .rd_sel(rd_sel),
      .rd_word(rd_word), .reg_flat(reg_flat)
   );

   typedef struct {
      logic [TW-1:0] exp;
      string         tag;
   } item_t;

   item_t     sb_q[$];
   int        n_run  = 0;
   int        n_fail = 0;
   logic [TW-1:0] m_reg  = '0;
   logic          m_prev = 1'b0;
   logic [15:0]   lfsr   = 16'hACE1;

   task automatic check(input bit ok, input string tag,
                        input logic [TW-1:0] act, input logic [TW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: one strobed evaluation, expected value pushed to scoreboard
   task automatic strobe(input logic d, input logic c, input logic k, input string tag);
      item_t it;
      @(negedge clk);
      eval = 1'b1; din = d; shift_cond = c; clr = k;
      if (k)                 m_reg = '0;
      else if (c && !m_prev) m_reg = {m_reg[TW-2:0], d};
      m_prev = c;
      @(posedge clk);
      #1;
      it.exp = m_reg; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // Driver: one idle cycle, inputs wiggle but nothing may change
   task automatic idle(input logic d, input logic c, input logic k, input string tag);
      item_t it;
      @(negedge clk);
      eval = 1'b0; din = d; shift_cond = c; clr = k;
      @(posedge clk);
      #1;
      it.exp = m_reg; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: compare each scoreboard item on the following falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(reg_flat == it.exp, it.tag, reg_flat, it.exp);
         end
      end
   end

   initial begin
      #(200000 * 5);
      check(1'b0, "watchdog expired", '0, '0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      #12;
      check(reg_flat == '0, "R1 contents under reset", reg_flat, '0);
      @(negedge clk); rst_n = 1'b1;

      // R1: history starts low, so a high condition at first strobe shifts
      strobe(1'b1, 1'b1, 1'b0, "R1 first strobe edge");
      // R4: held high, then falling, then low
      strobe(1'b0, 1'b1, 1'b0, "R4 condition held high");
      strobe(1'b1, 1'b0, 1'b0, "R4 condition falling");
      strobe(1'b1, 1'b0, 1'b0, "R4 condition held low");
      // R2: a 1 and a 0 entering
      strobe(1'b1, 1'b1, 1'b0, "R2 shift in one");
      strobe(1'b0, 1'b0, 1'b0, "R4 fall");
      strobe(1'b0, 1'b1, 1'b0, "R2 shift in zero");

      // R3: many edges to cross word boundaries and drop the top bit
      for (int i = 0; i < 150; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         strobe(lfsr[3], 1'b0, 1'b0, "R3 low phase");
         strobe(lfsr[0], 1'b1, 1'b0, "R3 edge shift");
      end
      check(reg_flat == m_reg, "R3 full register after overflow", reg_flat, m_reg);

      // R7: pulse between strobes gives no shift
      strobe(1'b1, 1'b0, 1'b0, "R7 history low");
      idle(1'b1, 1'b1, 1'b0, "R7 idle high");
      idle(1'b1, 1'b1, 1'b1, "R7 idle with clear");
      idle(1'b0, 1'b0, 1'b0, "R7 idle low");
      strobe(1'b1, 1'b0, 1'b0, "R7 no shift after pulse");
      // R7: low at strobe, rise while idle, high at next strobe -> shift
      idle(1'b0, 1'b1, 1'b0, "R7 idle rise");
      idle(1'b0, 1'b1, 1'b0, "R7 idle still high");
      strobe(1'b1, 1'b1, 1'b0, "R7 shift across idle gap");

      // R5: clear wins over edge, stays clear while held
      strobe(1'b1, 1'b0, 1'b0, "R5 prep low");
      strobe(1'b1, 1'b1, 1'b1, "R5 clear over edge");
      strobe(1'b1, 1'b0, 1'b1, "R5 clear held low");
      strobe(1'b1, 1'b1, 1'b1, "R5 clear held edge");
      // R6: condition high while clearing, still high on release -> no shift
      strobe(1'b1, 1'b1, 1'b0, "R6 no shift on release");
      strobe(1'b1, 1'b0, 1'b0, "R6 fall");
      strobe(1'b1, 1'b1, 1'b0, "R6 fresh edge shifts");
      for (int i = 0; i < 20; i++) begin
         strobe(1'b0, 1'b0, 1'b0, "R2 low phase");
         strobe(i[0], 1'b1, 1'b0, "R2 pattern shift");
      end

      // R8: read port
      @(negedge clk); eval = 1'b0;
      for (int s = 0; s < (1 << SEL_W); s++) begin
         logic [WW-1:0] e;
         rd_sel = SEL_W'(s);
         #1;
         e = (s < NW) ? m_reg[s*WW +: WW] : '0;
         check(rd_word == e, "R8 read port", TW'(rd_word), TW'(e));
      end

      // R1: mid-run reset clears contents and history
      strobe(1'b1, 1'b0, 1'b0, "R1 prep low");
      strobe(1'b1, 1'b1, 1'b0, "R1 prep edge");
      @(negedge clk); @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(reg_flat == '0, "R1 async clear", reg_flat, '0);
      m_reg = '0; m_prev = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      strobe(1'b1, 1'b1, 1'b0, "R1 history cleared by reset");
      strobe(1'b0, 1'b1, 1'b0, "R4 held after reset");

      @(negedge clk); @(negedge clk);
      eval = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule